// File: doc/BRIEF.md
# Host Controller Idle Flag and Reset-Acknowledge Sequencer

This block decides when a host controller may drop into the L1 low-power state and gate its backbone clock. It also paces the reset handshake with the platform power controller. Software sets an idle flag once it knows the controller will stay quiet for a long time. The flag can be cleared in three ways: software writes it back to zero, an MMIO access to the controller occurs, or the hardware leaves its idle state. The last two act only while their own policy enable is set. L1 is granted only while the flag is held. A second source of L1 permission, tied to the D3 device state, can be armed only after a separate override bit has been set.

On the reset side, the block waits for two things: a reset request from the power controller, and a report from the PHY that it has finished shutting down. It then counts a programmable delay, chosen by a 3-bit code with an uneven scale, and raises the reset acknowledge. The acknowledge stays high until the request is withdrawn.

Top module: `hc_idle_rst_seq`

## Requirements
- R1: After reset, `l1_permit`, `clk_gate_en` and `rst_ack` are 0, and every control field is 0.
- R2: A write with `cfg_wr_en` high loads the control fields on the next clock edge. The field positions in `cfg_wr_data` are: bit 0 controller L1 enable, bit 1 D3 L1 enable, bit 2 idle flag, bit 3 MMIO-clear policy, bit 4 idle-exit-clear policy, bit 5 D3 override, and bits 8:6 the wait code.
- R3: `l1_permit` = idle flag AND (controller L1 enable OR (D3 L1 enable AND `d3_state`)).
- R4: A write that sets the D3 L1 enable has no effect unless the D3 override bit is already 1. Writing 0 always clears the D3 L1 enable.
- R5: A software write of 0 to the idle flag clears it.
- R6: While the MMIO-clear policy is 1, an `mmio_access` pulse clears the idle flag. While the policy is 0, the pulse is ignored.
- R7: While the idle-exit-clear policy is 1, an `hw_idle_exit` pulse clears the idle flag. While the policy is 0, the pulse is ignored.
- R8: If a software write of 1 to the idle flag and an enabled hardware clear fall in the same cycle, the flag ends up 0.
- R9: `clk_gate_en` rises one cycle after `l1_permit` and `hw_idle` are both 1. It falls in the same cycle in which the idle flag reads 0 after a clear.
- R10: The wait code sets the number of added cycles between PHY shutdown and the acknowledge: 0 gives 0, 1 gives 128, 2 gives 256, 3 gives 512, 4 gives 1024, 5 gives 2048, 6 gives 4096 and 7 gives 131072.
- R11: With wait code 0, `rst_ack` rises in the cycle after `rst_req` and `phy_down_done` are first both sampled high.
- R12: The wait starts only when `phy_down_done` is seen during a request. `rst_ack` holds until `rst_req` falls. A request withdrawn during the wait abandons it, and the next request counts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control field write strobe |
| cfg_wr_data | input | 9 | Control field write value |
| mmio_access | input | 1 | An MMIO access hit the controller this cycle |
| hw_idle_exit | input | 1 | Hardware left its idle state this cycle |
| hw_idle | input | 1 | Hardware is currently idle |
| d3_state | input | 1 | Device is in the D3 power state |
| phy_down_done | input | 1 | PHY has finished shutting down |
| rst_req | input | 1 | Reset request from the power controller |
| l1_permit | output | 1 | L1 entry is allowed |
| clk_gate_en | output | 1 | Backbone clock may be gated |
| rst_ack | output | 1 | Reset acknowledge to the power controller |

## Verification
Two events can land in the same cycle: a software write that sets the idle flag, and an enabled hardware clear from an MMIO access. The bench drives both on one clock edge and expects the flag, and with it `l1_permit`, to read 0 afterwards. The second coincidence is between the idle flag clear and the clock-gate drop. After an MMIO clear, `clk_gate_en` and `l1_permit` are sampled together and must both be 0 in the very first cycle after the clear.

// File: rtl/hc_pm_pkg.sv
package hc_pm_pkg;

    localparam int unsigned CFG_W      = 9;
    localparam int unsigned F_CTL_L1   = 0;
    localparam int unsigned F_D3_L1    = 1;
    localparam int unsigned F_IDLE     = 2;
    localparam int unsigned F_POL_MMIO = 3;
    localparam int unsigned F_POL_EXIT = 4;
    localparam int unsigned F_D3_OVR   = 5;
    localparam int unsigned F_CODE_LO  = 6;
    localparam int unsigned CODE_W     = 3;

    typedef struct packed {
        logic              ctl_l1_en;
        logic              d3_l1_en;
        logic              idle_flag;
        logic              pol_mmio;
        logic              pol_exit;
        logic              d3_ovr;
        logic [CODE_W-1:0] wait_code;
    } pm_cfg_t;

    typedef enum logic [1:0] {
        RA_IDLE = 2'd0,
        RA_WAIT = 2'd1,
        RA_ACK  = 2'd2
    } ra_state_e;

    // Added cycles for a wait code: doubling steps from 2^base, top code jumps to 2^top.
    function automatic int unsigned wait_len(input logic [CODE_W-1:0] code,
                                             input int unsigned base_log2,
                                             input int unsigned top_log2);
        int unsigned sh;
        if (code == '0) begin
            return 0;
        end else if (code == '1) begin
            return 32'd1 << top_log2;
        end else begin
            sh = base_log2 + int'(code) - 1;
            return 32'd1 << sh;
        end
    endfunction

endpackage

// File: rtl/hc_idle_ctrl.sv
module hc_idle_ctrl
    import hc_pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    input  logic             mmio_access,
    input  logic             hw_idle_exit,
    output pm_cfg_t          cfg_o,
    output logic             idle_clr_o
);

    typedef struct packed {
        pm_cfg_t cfg;
    } idle_state_t;

    idle_state_t s_d, s_q;
    logic        hw_clr;

    always_comb begin
        s_d    = s_q;
        hw_clr = (mmio_access  && s_q.cfg.pol_mmio) ||
                 (hw_idle_exit && s_q.cfg.pol_exit);
        if (cfg_wr_en) begin
            s_d.cfg.ctl_l1_en = cfg_wr_data[F_CTL_L1];
            // D3 enable arms only behind an override that is already held
            s_d.cfg.d3_l1_en  = cfg_wr_data[F_D3_L1] && s_q.cfg.d3_ovr;
            s_d.cfg.idle_flag = cfg_wr_data[F_IDLE];
            s_d.cfg.pol_mmio  = cfg_wr_data[F_POL_MMIO];
            s_d.cfg.pol_exit  = cfg_wr_data[F_POL_EXIT];
            s_d.cfg.d3_ovr    = cfg_wr_data[F_D3_OVR];
            s_d.cfg.wait_code = cfg_wr_data[F_CODE_LO +: CODE_W];
        end
        // hardware clear takes priority over a same-cycle software set
        if (hw_clr) begin
            s_d.cfg.idle_flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o      = s_q.cfg;
    assign idle_clr_o = hw_clr;

    assert_d3_needs_ovr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.cfg.d3_l1_en) |-> $past(s_q.cfg.d3_ovr));

    assert_mmio_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_access && s_q.cfg.pol_mmio) |=> !s_q.cfg.idle_flag);

    assert_exit_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_idle_exit && s_q.cfg.pol_exit) |=> !s_q.cfg.idle_flag);

    assert_idle_set_only_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.cfg.idle_flag) |-> $past(cfg_wr_en));

endmodule

// File: rtl/hc_gate_ctrl.sv
module hc_gate_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_flag,
    input  logic ctl_l1_en,
    input  logic d3_l1_en,
    input  logic d3_state,
    input  logic hw_idle,
    input  logic idle_clr,
    output logic l1_permit,
    output logic clk_gate_en
);

    typedef struct packed {
        logic gate;
    } gate_state_t;

    gate_state_t s_d, s_q;
    logic        permit;

    always_comb begin
        permit     = idle_flag && (ctl_l1_en || (d3_l1_en && d3_state));
        s_d        = s_q;
        s_d.gate   = permit && hw_idle && !idle_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign l1_permit   = permit;
    // drops in the same cycle the flag reads clear
    assign clk_gate_en = s_q.gate && idle_flag;

    assert_gate_after_permit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_gate_en) |-> $past(l1_permit && hw_idle));

    assert_gate_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle_flag) |-> !clk_gate_en);

endmodule

// File: rtl/hc_rstack_wait.sv
module hc_rstack_wait
    import hc_pm_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 7,
    parameter int unsigned TOP_LOG2  = 17,
    parameter int unsigned CNT_W     = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] wait_code,
    input  logic              rst_req,
    input  logic              phy_down_done,
    output logic              rst_ack
);

    typedef struct packed {
        ra_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } ra_t;

    ra_t              s_d, s_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(wait_len(wait_code, BASE_LOG2, TOP_LOG2));

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            RA_IDLE: begin
                if (rst_req && phy_down_done) begin
                    s_d.cnt = '0;
                    s_d.lim = limit;
                    s_d.st  = (limit == '0) ? RA_ACK : RA_WAIT;
                end
            end
            RA_WAIT: begin
                if (!rst_req) begin
                    s_d.st = RA_IDLE;
                end else if (s_q.cnt == s_q.lim - 1'b1) begin
                    s_d.st = RA_ACK;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RA_ACK: begin
                if (!rst_req) begin
                    s_d.st = RA_IDLE;
                end
            end
            default: s_d.st = RA_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: RA_IDLE, cnt: '0, lim: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_ack = (s_q.st == RA_ACK);

    assert_ack_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ack |-> $past(rst_req));

    assert_cnt_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == RA_WAIT) |-> (s_q.cnt < s_q.lim));

    assert_zero_code_direct_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == RA_IDLE) && rst_req && phy_down_done && (wait_code == '0)) |=> rst_ack);

    assert_wait_needs_phy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.st) == RA_IDLE && s_q.st != RA_IDLE) |-> $past(phy_down_done));

endmodule

// File: rtl/hc_idle_rst_seq.sv
module hc_idle_rst_seq
    import hc_pm_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 7,
    parameter int unsigned TOP_LOG2  = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    input  logic             mmio_access,
    input  logic             hw_idle_exit,
    input  logic             hw_idle,
    input  logic             d3_state,
    input  logic             phy_down_done,
    input  logic             rst_req,
    output logic             l1_permit,
    output logic             clk_gate_en,
    output logic             rst_ack
);

    localparam int unsigned TOP_W  = (BASE_LOG2 + 6 > TOP_LOG2) ? BASE_LOG2 + 6 : TOP_LOG2;
    localparam int unsigned CNT_W  = TOP_W + 1;

    pm_cfg_t cfg;
    logic    idle_clr;

    hc_idle_ctrl u_idle (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_data  (cfg_wr_data),
        .mmio_access  (mmio_access),
        .hw_idle_exit (hw_idle_exit),
        .cfg_o        (cfg),
        .idle_clr_o   (idle_clr)
    );

    hc_gate_ctrl u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_flag   (cfg.idle_flag),
        .ctl_l1_en   (cfg.ctl_l1_en),
        .d3_l1_en    (cfg.d3_l1_en),
        .d3_state    (d3_state),
        .hw_idle     (hw_idle),
        .idle_clr    (idle_clr),
        .l1_permit   (l1_permit),
        .clk_gate_en (clk_gate_en)
    );

    hc_rstack_wait #(
        .BASE_LOG2 (BASE_LOG2),
        .TOP_LOG2  (TOP_LOG2),
        .CNT_W     (CNT_W)
    ) u_wait (
        .clk           (clk),
        .rst_n         (rst_n),
        .wait_code     (cfg.wait_code),
        .rst_req       (rst_req),
        .phy_down_done (phy_down_done),
        .rst_ack       (rst_ack)
    );

    assert_permit_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        l1_permit |-> cfg.idle_flag);

    assert_sw_zero_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_wr_data[F_IDLE]) |=> !l1_permit);

endmodule

// File: tb/sim_hc_idle_rst_seq.sv
module sim_hc_idle_rst_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [8:0] cfg_wr_data = '0;
    logic       mmio_access = 1'b0;
    logic       hw_idle_exit = 1'b0;
    logic       hw_idle = 1'b0;
    logic       d3_state = 1'b0;
    logic       phy_down_done = 1'b0;
    logic       rst_req = 1'b0;
    logic       l1_permit, clk_gate_en, rst_ack;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned cyc = 0;
    int unsigned exp_q[$];
    logic        ack_prev = 1'b0;

    localparam logic [8:0] B_CTL = 9'h001, B_D3 = 9'h002, B_IDLE = 9'h004,
                           B_PM  = 9'h008, B_PX = 9'h010, B_OVR = 9'h020;

    always #2 clk = ~clk;

    hc_idle_rst_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .mmio_access(mmio_access), .hw_idle_exit(hw_idle_exit), .hw_idle(hw_idle),
        .d3_state(d3_state), .phy_down_done(phy_down_done), .rst_req(rst_req),
        .l1_permit(l1_permit), .clk_gate_en(clk_gate_en), .rst_ack(rst_ack)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int unsigned exp_len(input int code);
        case (code)
            0: return 0;
            1: return 128;
            2: return 256;
            3: return 512;
            4: return 1024;
            5: return 2048;
            6: return 4096;
            default: return 131072;
        endcase
    endfunction

    // monitor: pops the expected acknowledge cycle at each rising edge of rst_ack
    always @(negedge clk) begin
        if (rst_n && rst_ack && !ack_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected ack", int'(cyc), -1);
            end else begin
                int unsigned e;
                e = exp_q.pop_front();
                chk(cyc == e, "R10 ack cycle", int'(cyc), int'(e));
            end
        end
        ack_prev = rst_ack;
    end

    task automatic wr(input logic [8:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        #1;
    endtask

    task automatic pulse_mmio();
        @(negedge clk); mmio_access = 1'b1;
        @(negedge clk); mmio_access = 1'b0;
        #1;
    endtask

    task automatic pulse_exit();
        @(negedge clk); hw_idle_exit = 1'b1;
        @(negedge clk); hw_idle_exit = 1'b0;
        #1;
    endtask

    // driver: one full request, pushing the expected ack cycle
    task automatic run_req(input int code, input int pre);
        wr(9'(code) << 6);
        @(negedge clk);
        rst_req = 1'b1; phy_down_done = 1'b0;
        repeat (pre) @(negedge clk);
        #1 chk(rst_ack == 1'b0, "R12 no ack before phy done", rst_ack, 0);
        @(negedge clk);
        phy_down_done = 1'b1;
        exp_q.push_back(cyc + 1 + exp_len(code));
        do @(negedge clk); while (!rst_ack);
        repeat (5) @(negedge clk);
        #1 chk(rst_ack == 1'b1, "R12 ack held", rst_ack, 1);
        rst_req = 1'b0; phy_down_done = 1'b0;
        @(negedge clk);
        #1 chk(rst_ack == 1'b0, "R12 ack drops", rst_ack, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1
        chk(!l1_permit && !clk_gate_en && !rst_ack, "R1 reset outputs",
            {l1_permit, clk_gate_en, rst_ack}, 0);

        // R2 / R3
        wr(B_CTL | B_IDLE);
        chk(l1_permit == 1'b1, "R2 R3 ctl enable with flag", l1_permit, 1);
        wr(B_IDLE);
        chk(l1_permit == 1'b0, "R3 no enable", l1_permit, 0);

        // R4
        d3_state = 1'b1;
        wr(B_IDLE | B_D3);
        chk(l1_permit == 1'b0, "R4 d3 set without override ignored", l1_permit, 0);
        wr(B_OVR);
        wr(B_OVR | B_D3 | B_IDLE);
        chk(l1_permit == 1'b1, "R4 d3 set with override", l1_permit, 1);
        d3_state = 1'b0; #1;
        chk(l1_permit == 1'b0, "R3 d3 path needs d3_state", l1_permit, 0);
        wr(B_OVR | B_IDLE);
        d3_state = 1'b1; #1;
        chk(l1_permit == 1'b0, "R4 writing 0 clears d3 enable", l1_permit, 0);
        d3_state = 1'b0;

        // R5
        wr(B_CTL | B_IDLE);
        wr(B_CTL);
        chk(l1_permit == 1'b0, "R5 sw write 0 clears", l1_permit, 0);

        // R6
        wr(B_CTL | B_IDLE);
        pulse_mmio();
        chk(l1_permit == 1'b1, "R6 mmio ignored without policy", l1_permit, 1);
        wr(B_CTL | B_IDLE | B_PM);
        pulse_mmio();
        chk(l1_permit == 1'b0, "R6 mmio clears with policy", l1_permit, 0);

        // R7
        wr(B_CTL | B_IDLE);
        pulse_exit();
        chk(l1_permit == 1'b1, "R7 exit ignored without policy", l1_permit, 1);
        wr(B_CTL | B_IDLE | B_PX);
        pulse_exit();
        chk(l1_permit == 1'b0, "R7 exit clears with policy", l1_permit, 0);

        // R8: same-cycle sw set and hw clear
        wr(B_CTL | B_PM);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = B_CTL | B_PM | B_IDLE; mmio_access = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0; mmio_access = 1'b0; #1;
        chk(l1_permit == 1'b0, "R8 hw clear wins", l1_permit, 0);

        // R9
        wr(B_CTL | B_IDLE | B_PM);
        hw_idle = 1'b1; #1;
        chk(clk_gate_en == 1'b0, "R9 gate not yet", clk_gate_en, 0);
        @(negedge clk); #1;
        chk(clk_gate_en == 1'b1, "R9 gate one cycle later", clk_gate_en, 1);
        pulse_mmio();
        chk(!clk_gate_en && !l1_permit, "R9 gate drops with flag clear",
            {clk_gate_en, l1_permit}, 0);
        hw_idle = 1'b0;

        // R10 / R11 / R12
        run_req(0, 4);   // R11
        run_req(1, 20);  // R10
        run_req(3, 3);   // R10
        run_req(5, 2);   // R10

        // R12 restart: withdraw mid-wait, new request counts from zero
        wr(9'(1) << 6);
        @(negedge clk);
        rst_req = 1'b1; phy_down_done = 1'b1;
        repeat (60) @(negedge clk);
        rst_req = 1'b0; phy_down_done = 1'b0;
        repeat (2) @(negedge clk);
        #1 chk(rst_ack == 1'b0, "R12 abandoned wait", rst_ack, 0);
        @(negedge clk);
        rst_req = 1'b1; phy_down_done = 1'b1;
        exp_q.push_back(cyc + 1 + 128);
        do @(negedge clk); while (!rst_ack);
        rst_req = 1'b0; phy_down_done = 1'b0;
        @(negedge clk);

        run_req(7, 2);   // R10 long code

        #1 chk(exp_q.size() == 0, "R10 all acks seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule